// File: doc/BRIEF.md
# Sequential Restoring Fixed-Point Divider

This block divides one 32-bit fixed-point word by another over many clock cycles. Each word is sign-magnitude. Bit 31 is the sign, where 1 means negative. Bits 30:0 hold an unsigned magnitude, and the lowest 15 of those bits are the fraction. That gives 16 integer bits and 15 fraction bits. The quotient uses the same layout.

When `start_i` is accepted, the block takes the magnitude of the dividend and scales it up by 2^15, so that the quotient keeps 15 fraction bits. The scaled dividend is placed in the low half of a double-length shift register, and the upper half is cleared. The upper half then acts as a partial remainder with a guard sign bit. The block runs one restoring step per clock, 46 steps in all:
- The register shifts left by one bit.
- The divisor magnitude is subtracted from the upper half.
- A negative result is undone by adding the divisor back.
- Each step shifts one quotient bit into the low end of the register.

When the steps are done, the block publishes the quotient, the overflow flag and a one-cycle completion pulse. A zero divisor skips the loop and finishes at once.

A caller applies the operands with `start_i` for one cycle while `busy_o` is low. It then waits for `complete_o` and reads `quotient_o` and `overflow_o`. Both results hold their values until the next completion.

Top module: `qdiv_top`

## Requirements
- R1: For a nonzero divisor whose quotient fits, `quotient_o[30:0]` equals floor((|dividend| * 2^15) / |divisor|). Here |x| is bits 30:0 of the word, and the result has 15 fraction bits.
- R2: `quotient_o[31]` is the XOR of bit 31 of the two operands. It is forced to 0 whenever `quotient_o[30:0]` is zero.
- R3: A start accepted with a nonzero divisor gives the following timing:
  - `busy_o` is high from the accepting edge until the completing edge.
  - `complete_o` is high for exactly one cycle, after the 46th clock edge that follows the accepting edge.
- R4: A divisor with magnitude zero gives:
  - `complete_o` in the cycle right after the accepting edge, with no busy period.
  - `overflow_o` = 1.
  - `quotient_o[30:0]` all ones.
- R5: When the exact quotient magnitude needs more than 31 bits, `overflow_o` = 1 and `quotient_o[30:0]` saturates to all ones.
- R6: `start_i` asserted while `busy_o` is high is ignored, and the running division completes with its original operands.
- R7: After reset, `quotient_o`, `overflow_o`, `complete_o` and `busy_o` are 0. The results hold their values between completions.
- R8: `overflow_o` is 0 for every in-range quotient, including the largest magnitude 2^31-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept operands when idle |
| dividend_i | input | 32 | Sign-magnitude dividend, 15 fraction bits |
| divisor_i | input | 32 | Sign-magnitude divisor, 15 fraction bits |
| busy_o | output | 1 | Division loop running |
| complete_o | output | 1 | One-cycle done pulse |
| overflow_o | output | 1 | Zero divisor or quotient too large |
| quotient_o | output | 32 | Sign-magnitude quotient, 15 fraction bits |

## Verification
The bench drives inputs on falling edges and counts rising edges from the one that accepts `start_i` until `complete_o` is seen high at a falling edge. The result is due at count 47 for a nonzero divisor and at count 1 for a zero divisor. The latency is checked as a value in its own right before the quotient and the overflow flag are compared. One cycle later the bench confirms that the pulse has dropped and that the results are unchanged. A start issued mid-run must leave both the latency and the quotient of the running division untouched.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;
  localparam int WORD_W_DEF = 32;
  localparam int FRAC_W_DEF = 15;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } qdiv_state_e;
endpackage

// File: rtl/qdiv_unpack.sv
module qdiv_unpack #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              sign_o,
  output logic [WORD_W-2:0] mag_o,
  output logic              zero_o
);
  assign sign_o = word_i[WORD_W-1];
  assign mag_o  = word_i[WORD_W-2:0];
  assign zero_o = (word_i[WORD_W-2:0] == '0);
endmodule

// File: rtl/qdiv_step.sv
module qdiv_step #(
  parameter int MAG_W = 31,
  parameter int DVD_W = 46
) (
  input  logic [MAG_W:0]   rem_i,
  input  logic [DVD_W-1:0] quo_i,
  input  logic [MAG_W-1:0] dvs_i,
  output logic [MAG_W:0]   rem_o,
  output logic [DVD_W-1:0] quo_o
);
  localparam int TW = MAG_W + 2;

  logic [TW-1:0]  shifted;
  logic [TW-1:0]  trial;
  logic [MAG_W:0] restored;
  logic           neg;

  // shift left, then trial subtract with a guard sign bit
  assign shifted  = {rem_i, quo_i[DVD_W-1]};
  assign trial    = shifted - {2'b00, dvs_i};
  assign neg      = trial[TW-1];
  assign restored = trial[MAG_W:0] + {1'b0, dvs_i};

  assign rem_o = neg ? restored : trial[MAG_W:0];
  assign quo_o = {quo_i[DVD_W-2:0], ~neg};
endmodule

// File: rtl/qdiv_pack.sv
module qdiv_pack #(
  parameter int MAG_W = 31,
  parameter int DVD_W = 46
) (
  input  logic [DVD_W-1:0] quo_raw_i,
  input  logic             sign_i,
  input  logic             dvs_zero_i,
  output logic [MAG_W:0]   word_o,
  output logic             ovf_o
);
  logic             too_big;
  logic [MAG_W-1:0] mag;

  assign too_big = |quo_raw_i[DVD_W-1:MAG_W];
  assign ovf_o   = dvs_zero_i | too_big;
  assign mag     = ovf_o ? '1 : quo_raw_i[MAG_W-1:0];
  assign word_o  = {sign_i & (mag != '0), mag};

  always_comb begin
    a_r5_sat_mag: assert (!too_big || (&word_o[MAG_W-1:0]));
    a_r2_zero_pos: assert ((word_o[MAG_W-1:0] != '0) || !word_o[MAG_W]);
  end
endmodule

// File: rtl/qdiv_top.sv
module qdiv_top
  import qdiv_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] dividend_i,
  input  logic [WORD_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              complete_o,
  output logic              overflow_o,
  output logic [WORD_W-1:0] quotient_o
);
  localparam int MAG_W = WORD_W - 1;
  localparam int DVD_W = MAG_W + FRAC_W;
  localparam int ITER  = DVD_W;
  localparam int CNT_W = $clog2(ITER + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

  qdiv_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MAG_W:0]   rem_q;
  logic [DVD_W-1:0] quo_q;
  logic [MAG_W-1:0] dvs_q;
  logic             sign_q;

  logic             a_sign, b_sign, a_zero, b_zero;
  logic [MAG_W-1:0] a_mag, b_mag;
  logic [MAG_W:0]   rem_nx;
  logic [DVD_W-1:0] quo_nx;
  logic             pk_sign, pk_zero;
  logic [MAG_W:0]   pk_word;
  logic             pk_ovf;
  logic             accept;

  qdiv_unpack #(.WORD_W(WORD_W)) u_unpack_a (
    .word_i(dividend_i), .sign_o(a_sign), .mag_o(a_mag), .zero_o(a_zero)
  );
  qdiv_unpack #(.WORD_W(WORD_W)) u_unpack_b (
    .word_i(divisor_i), .sign_o(b_sign), .mag_o(b_mag), .zero_o(b_zero)
  );

  qdiv_step #(.MAG_W(MAG_W), .DVD_W(DVD_W)) u_step (
    .rem_i(rem_q), .quo_i(quo_q), .dvs_i(dvs_q), .rem_o(rem_nx), .quo_o(quo_nx)
  );

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign pk_sign = (state_q == ST_IDLE) ? (a_sign ^ b_sign) : sign_q;
  assign pk_zero = (state_q == ST_IDLE);

  qdiv_pack #(.MAG_W(MAG_W), .DVD_W(DVD_W)) u_pack (
    .quo_raw_i(quo_nx), .sign_i(pk_sign), .dvs_zero_i(pk_zero),
    .word_o(pk_word), .ovf_o(pk_ovf)
  );

  assign busy_o = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rem_q      <= '0;
      quo_q      <= '0;
      dvs_q      <= '0;
      sign_q     <= 1'b0;
      complete_o <= 1'b0;
      overflow_o <= 1'b0;
      quotient_o <= '0;
    end else begin
      complete_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (b_zero) begin
              complete_o <= 1'b1;
              overflow_o <= pk_ovf;
              quotient_o <= pk_word;
            end else begin
              state_q <= ST_RUN;
              cnt_q   <= '0;
              rem_q   <= '0;
              quo_q   <= {a_mag, {FRAC_W{1'b0}}};
              dvs_q   <= b_mag;
              sign_q  <= a_sign ^ b_sign;
            end
          end
        end
        ST_RUN: begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            state_q    <= ST_IDLE;
            complete_o <= 1'b1;
            overflow_o <= pk_ovf;
            quotient_o <= pk_word;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: partial remainder stays below divisor during the loop
  a_r1_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rem_q < {1'b0, dvs_q}));
  a_r3_iter_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q <= LAST));
  a_r3_complete_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_o |=> !complete_o);
  a_r3_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && complete_o));
  a_r4_zero_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && b_zero) |=> (complete_o && overflow_o && !busy_o));
  a_r5_ovf_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (complete_o && overflow_o) |-> (&quotient_o[MAG_W-1:0]));
  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && cnt_q != LAST) |=> busy_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !complete_o |-> ($stable(quotient_o) && $stable(overflow_o)));
endmodule

// File: tb/qdiv_top_tb_top.sv
module qdiv_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NORM_LAT   = 47;
  localparam int NV         = 14;

  // {dividend, divisor, expected quotient, expected overflow}
  localparam logic [127:0] VEC [0:NV-1] = '{
    {32'h0004_0000, 32'h0001_0000, 32'h0002_0000, 32'd0}, // 8/2
    {32'h8003_0000, 32'h0000_C000, 32'h8002_0000, 32'd0}, // -6/1.5
    {32'h8000_8000, 32'h8000_4000, 32'h0001_0000, 32'd0}, // -1/-0.5
    {32'h0000_8000, 32'h0001_8000, 32'h0000_2AAA, 32'd0}, // 1/3
    {32'h0000_0000, 32'h8002_8000, 32'h0000_0000, 32'd0}, // 0/-5
    {32'h8000_0000, 32'h0000_8000, 32'h0000_0000, 32'd0}, // -0/1
    {32'h7FFF_FFFF, 32'h0000_0001, 32'h7FFF_FFFF, 32'd1}, // overflow
    {32'hFFFF_FFFF, 32'h0000_4000, 32'hFFFF_FFFF, 32'd1}, // neg overflow
    {32'h4000_0000, 32'h0000_8000, 32'h4000_0000, 32'd0}, // /1.0
    {32'h7FFF_FFFF, 32'h0000_8000, 32'h7FFF_FFFF, 32'd0}, // max fits
    {32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 32'd1}, // just over
    {32'h0003_0000, 32'h0000_0000, 32'h7FFF_FFFF, 32'd1}, // zero div
    {32'h8003_0000, 32'h8000_0000, 32'h7FFF_FFFF, 32'd1}, // -x / -0
    {32'h8003_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'd1}  // -x / +0
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [31:0] divisor_i = '0;
  logic        busy_o, complete_o, overflow_o;
  logic [31:0] quotient_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  qdiv_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .complete_o(complete_o),
    .overflow_o(overflow_o), .quotient_o(quotient_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] eq, input logic eo, input bit mid_start);
    int lat;
    int exp_lat;
    logic [31:0] q_seen;
    exp_lat = (b[30:0] == '0) ? 1 : NORM_LAT;
    @(negedge clk_i);
    dividend_i = a; divisor_i = b; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    if (exp_lat != 1) check("R3 busy after accept", 32'(busy_o), 32'd1);
    while (!complete_o && lat < 200) begin
      if (mid_start && lat == 10) begin
        dividend_i = 32'h0001_0000; divisor_i = 32'h0000_8000; start_i = 1'b1;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end
    if (exp_lat == 1) check("R4 zero-divisor latency", 32'(lat), 32'(exp_lat));
    else              check("R3 latency", 32'(lat), 32'(exp_lat));
    check(mid_start ? "R6 quotient unaffected" : "R1/R2/R5 quotient", quotient_o, eq);
    check(eo ? "R4/R5 overflow set" : "R8 overflow clear", 32'(overflow_o), 32'(eo));
    q_seen = quotient_o;
    @(negedge clk_i);
    check("R3 complete one cycle", 32'(complete_o), 32'd0);
    check("R7 quotient held", quotient_o, q_seen);
    check("R7 busy idle", 32'(busy_o), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R7 reset quotient", quotient_o, 32'h0);
    check("R7 reset overflow", 32'(overflow_o), 32'd0);
    check("R7 reset complete", 32'(complete_o), 32'd0);
    check("R7 reset busy", 32'(busy_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][127:96], VEC[i][95:64], VEC[i][63:32], VEC[i][0], 1'b0);
    end
    // R6: start mid-run is ignored
    run_op(32'h0004_0000, 32'h0001_0000, 32'h0002_0000, 1'b0, 1'b1);
    // R7: idle cycles without start keep results
    repeat (5) @(negedge clk_i);
    check("R7 hold while idle", quotient_o, 32'h0002_0000);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule